// File: doc/BRIEF.md
# Serial Flash Custom Command Engine

This block sends one host-defined command to an external serial NOR flash over a single-line SPI link and collects whatever the flash sends back. The host supplies an opcode, a byte count of 1 to 9, and two 32-bit words of outgoing data. It also supplies the static levels for the two spare IO lines, the clock divider, the SPI mode, a chip-select guard delay and two option flags. A single-cycle `start` pulse launches the command. The engine captures all of these settings at that moment and runs the complete sequence without further help from the host.

If the host asks for it, the engine puts a write-enable frame in front of the command. It can also follow the command with repeated status-register reads until the flash reports that its internal operation has finished. Bytes clocked in during the data phase of the command replace the matching bytes of the two words, so the host reads the reply from `dataOut0`/`dataOut1`. When the whole sequence is done, `ready` pulses for one cycle.

Top module: `sfci_engine`

## Requirements
- R1: After reset, `csN` is 1, `busy` and `ready` are 0, `io2` and `io3` are 1, and `sck` is 0 while `mode3` is 0.
- R2: The command frame carries the opcode first, then `n-1` data bytes, where `n` is `lenField` limited to the range 1..9 (0 gives 1 and values above 9 give 9). Data byte k comes from byte k of the 64-bit value {wrData1, wrData0}, with byte 0 being bits 7:0 of wrData0. Data bytes go out in rising k order, each with the most significant bit first.
- R3: The byte received during data byte k replaces byte k of the captured 64-bit value, seen on {dataOut1, dataOut0}. Bytes beyond the command length keep their captured values. The outputs hold these values until the next accepted start, whatever the data inputs do.
- R4: With `wrenPrefix` set, a separate one-byte frame carrying 0x06 comes before the command frame.
- R5: With `waitBusy` set, each status poll after the command is a two-byte frame: opcode 0x05 followed by one byte read back. Polls repeat while bit 0 of the byte read back is 1, and the sequence ends after the first poll that returns 0.
- R6: While `busy` is 1, `io2`/`io3` stay at the levels captured at start. While idle they are 1.
- R7: During a byte, each SCK half period lasts `divField+1` clock cycles.
- R8: SCK idles at 0 when `mode3` is 0 and at 1 when `mode3` is 1. The flash-side sample point is the rising SCK edge in both modes.
- R9: With D = `csDelay` × DLY_UNIT cycles, at least D cycles pass from the falling edge of `csN` to the first SCK edge, and at least D cycles pass from the last SCK edge to the rising edge of `csN`. Between frames of one sequence, `csN` stays high for at least D cycles.
- R10: `busy` is 1 from the cycle after an accepted start until the sequence ends. `ready` is then 1 for exactly one cycle, with `busy` already 0.
- R11: A `start` pulse while `busy` is 1 is ignored: it adds no frames and changes neither the sent bytes nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the SCK reference rate |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse |
| opcode | input | 8 | Command opcode |
| lenField | input | 4 | Total bytes on the bus (1..9, limited) |
| wrData0 | input | 32 | Outgoing data bytes 0..3 |
| wrData1 | input | 32 | Outgoing data bytes 4..7 |
| io2Level | input | 1 | Level for IO2 during a command |
| io3Level | input | 1 | Level for IO3 during a command |
| wrenPrefix | input | 1 | Send a write-enable frame first |
| waitBusy | input | 1 | Poll status until the busy bit clears |
| divField | input | 4 | SCK half period minus one, in clocks |
| mode3 | input | 1 | 0: SPI mode 0, 1: SPI mode 3 |
| csDelay | input | 8 | Chip-select guard, in units of DLY_UNIT clocks |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| io2 | output | 1 | Static IO2 level |
| io3 | output | 1 | Static IO3 level |
| busy | output | 1 | Sequence in progress |
| ready | output | 1 | One-cycle completion pulse |
| dataOut0 | output | 32 | Result bytes 0..3 |
| dataOut1 | output | 32 | Result bytes 4..7 |

## Verification
The engine is driven with random opcodes, lengths, data words, dividers, delays and flag combinations from a fixed seed. A bench flash model captures every frame and answers with random reply bytes. Directed cases cover length 0 and lengths above 9, which show whether the length limit holds at both ends. A maximum-length command with random data separates byte-order and word-selection faults. Write-enable combined with several busy status replies separates a missing prefix from a wrong number of polls, and mode 3 with a large divider separates idle-level faults from half-period faults. A second start while the engine is busy, followed by changes to the data inputs once it has finished, shows whether the captured settings and results are kept.

// File: rtl/sfci_pkg.sv
package sfci_pkg;

  localparam logic [7:0] WREN_OPC = 8'h06;
  localparam logic [7:0] RDSR_OPC = 8'h05;

  typedef enum logic [2:0] {
    TX_OPC  = 3'd0,
    TX_WREN = 3'd1,
    TX_STAT = 3'd2,
    TX_DATA = 3'd3,
    TX_ZERO = 3'd4
  } txSel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic       running;
    logic       capture;
    logic       byteGo;
    txSel_e     txSel;
    logic [2:0] txIdx;
    logic       storeRx;
    logic [2:0] rxIdx;
  } ctlStb_t;

endpackage

// File: rtl/sfci_ctrl.sv
module sfci_ctrl
  import sfci_pkg::*;
#(
  parameter int DLY_W    = 8,
  parameter int DLY_UNIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [3:0]       lenField,
  input  logic             wrenPrefix,
  input  logic             waitBusy,
  input  logic [DLY_W-1:0] dlyField,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  output ctlStb_t          stb,
  output logic             csN,
  output logic             busy,
  output logic             ready
);

  localparam int TW = DLY_W + $clog2(DLY_UNIT) + 1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_SHIFT, S_HOLD, S_GAP} state_e;
  typedef enum logic [1:0] {F_WREN, F_CMD, F_STAT} frame_e;

  state_e        state;
  frame_e        frame, nextFrame;
  logic [3:0]    byteIdx, nBytes, lenClamp, frameLen;
  logic          wrenQ, waitQ, wipQ, readyQ, haveNext, lastByte;
  logic [TW-1:0] timer, dlyQ, dlyIn;

  assign dlyIn    = TW'(dlyField) * TW'(DLY_UNIT);
  assign lenClamp = (lenField == 4'd0) ? 4'd1 : ((lenField > 4'd9) ? 4'd9 : lenField);

  always_comb begin
    case (frame)
      F_WREN:  frameLen = 4'd1;
      F_STAT:  frameLen = 4'd2;
      default: frameLen = nBytes;
    endcase
  end

  assign lastByte = (byteIdx + 4'd1) == frameLen;

  always_comb begin
    nextFrame = F_STAT;
    haveNext  = 1'b0;
    case (frame)
      F_WREN: begin nextFrame = F_CMD; haveNext = 1'b1; end
      F_CMD:  haveNext = waitQ;
      default: haveNext = wipQ;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.txSel   = TX_ZERO;
    stb.running = (state != S_IDLE);
    case (state)
      S_IDLE: stb.capture = start;
      S_SETUP: if (timer == '0) begin
        stb.byteGo = 1'b1;
        stb.txSel  = (frame == F_WREN) ? TX_WREN : ((frame == F_STAT) ? TX_STAT : TX_OPC);
      end
      S_SHIFT: if (byteDone) begin
        if (frame == F_CMD && byteIdx != 4'd0) begin
          stb.storeRx = 1'b1;
          stb.rxIdx   = 3'(byteIdx - 4'd1);
        end
        if (!lastByte) begin
          stb.byteGo = 1'b1;
          stb.txSel  = (frame == F_CMD) ? TX_DATA : TX_ZERO;
          stb.txIdx  = byteIdx[2:0];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      frame   <= F_CMD;
      byteIdx <= '0;
      nBytes  <= 4'd1;
      wrenQ   <= 1'b0;
      waitQ   <= 1'b0;
      wipQ    <= 1'b0;
      dlyQ    <= '0;
      timer   <= '0;
      readyQ  <= 1'b0;
    end else begin
      readyQ <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          nBytes  <= lenClamp;
          wrenQ   <= wrenPrefix;
          waitQ   <= waitBusy;
          dlyQ    <= dlyIn;
          timer   <= dlyIn;
          frame   <= wrenPrefix ? F_WREN : F_CMD;
          byteIdx <= '0;
          state   <= S_SETUP;
        end
        S_SETUP: begin
          if (timer == '0) state <= S_SHIFT;
          else timer <= timer - 1'b1;
        end
        S_SHIFT: if (byteDone) begin
          if (frame == F_STAT && byteIdx != 4'd0) wipQ <= rxByte[0];
          if (lastByte) begin
            state <= S_HOLD;
            timer <= dlyQ;
          end else begin
            byteIdx <= byteIdx + 4'd1;
          end
        end
        S_HOLD: begin
          if (timer == '0) begin
            state <= S_GAP;
            timer <= dlyQ;
          end else timer <= timer - 1'b1;
        end
        default: begin
          if (timer != '0) timer <= timer - 1'b1;
          else if (haveNext) begin
            frame   <= nextFrame;
            byteIdx <= '0;
            timer   <= dlyQ;
            state   <= S_SETUP;
          end else begin
            state  <= S_IDLE;
            readyQ <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign csN   = !(state == S_SETUP || state == S_SHIFT || state == S_HOLD);
  assign ready = readyQ;

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> !ready);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(nBytes) && $stable(dlyQ) && $stable(waitQ)));

endmodule

// File: rtl/sfci_datapath.sv
module sfci_datapath
  import sfci_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic [7:0]       opcode,
  input  logic [31:0]      wrData0,
  input  logic [31:0]      wrData1,
  input  logic [DIV_W-1:0] divField,
  input  logic             mode3,
  input  logic             io2Level,
  input  logic             io3Level,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             io2,
  output logic             io3,
  output logic             byteDone,
  output logic [7:0]       rxByte,
  output logic [31:0]      dataOut0,
  output logic [31:0]      dataOut1
);

  localparam int WORDS = 2;
  localparam int DW    = WORDS * 32;

  logic [7:0]       opcQ, txByte, txShift, rxShift;
  logic [DIV_W-1:0] divQ, divCnt;
  logic [2:0]       bitCnt;
  logic [DW-1:0]    dataReg;
  logic [1:0]       lvlQ;
  logic             modeQ, active, phaseB;

  always_comb begin
    case (stb.txSel)
      TX_OPC:  txByte = opcQ;
      TX_WREN: txByte = WREN_OPC;
      TX_STAT: txByte = RDSR_OPC;
      TX_DATA: txByte = dataReg[{stb.txIdx, 3'b000} +: 8];
      default: txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcQ     <= '0;
      divQ     <= '0;
      modeQ    <= 1'b0;
      lvlQ     <= 2'b11;
      dataReg  <= '0;
      active   <= 1'b0;
      phaseB   <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (!stb.running) modeQ <= mode3;
      if (stb.capture) begin
        opcQ    <= opcode;
        divQ    <= divField;
        lvlQ    <= {io3Level, io2Level};
        dataReg <= {wrData1, wrData0};
      end
      if (stb.storeRx) dataReg[{stb.rxIdx, 3'b000} +: 8] <= rxShift;
      if (stb.byteGo) begin
        active  <= 1'b1;
        phaseB  <= 1'b0;
        divCnt  <= '0;
        bitCnt  <= '0;
        txShift <= txByte;
      end else if (active) begin
        if (divCnt == divQ) begin
          divCnt <= '0;
          if (!phaseB) begin
            phaseB  <= 1'b1;
            rxShift <= {rxShift[6:0], miso};
          end else begin
            phaseB <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt  <= bitCnt + 3'd1;
              txShift <= {txShift[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
    end
  end

  assign sck    = active ? phaseB : modeQ;
  assign mosi   = txShift[7];
  assign rxByte = rxShift;

  // spare IO lines share one structure
  logic [1:0] ioOut;
  for (genvar g = 0; g < 2; g++) begin : g_io
    assign ioOut[g] = stb.running ? lvlQ[g] : 1'b1;
  end
  assign io2 = ioOut[0];
  assign io3 = ioOut[1];

  assign dataOut0 = dataReg[31:0];
  assign dataOut1 = dataReg[63:32];

  // R7
  byte_go_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.byteGo |-> !active);

  // R6
  io_static_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.running && $past(stb.running)) |-> ($stable(io2) && $stable(io3)));

endmodule

// File: rtl/sfci_engine.sv
module sfci_engine
  import sfci_pkg::*;
#(
  parameter int DIV_W    = 4,
  parameter int DLY_W    = 8,
  parameter int DLY_UNIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [3:0]       lenField,
  input  logic [31:0]      wrData0,
  input  logic [31:0]      wrData1,
  input  logic             io2Level,
  input  logic             io3Level,
  input  logic             wrenPrefix,
  input  logic             waitBusy,
  input  logic [DIV_W-1:0] divField,
  input  logic             mode3,
  input  logic [DLY_W-1:0] csDelay,
  input  logic             miso,
  output logic             sck,
  output logic             csN,
  output logic             mosi,
  output logic             io2,
  output logic             io3,
  output logic             busy,
  output logic             ready,
  output logic [31:0]      dataOut0,
  output logic [31:0]      dataOut1
);

  ctlStb_t    stb;
  logic       byteDone;
  logic [7:0] rxByte;

  sfci_ctrl #(.DLY_W(DLY_W), .DLY_UNIT(DLY_UNIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .lenField(lenField),
    .wrenPrefix(wrenPrefix), .waitBusy(waitBusy), .dlyField(csDelay),
    .byteDone(byteDone), .rxByte(rxByte), .stb(stb), .csN(csN),
    .busy(busy), .ready(ready)
  );

  sfci_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opcode(opcode),
    .wrData0(wrData0), .wrData1(wrData1), .divField(divField),
    .mode3(mode3), .io2Level(io2Level), .io3Level(io3Level),
    .miso(miso), .sck(sck), .mosi(mosi), .io2(io2), .io3(io3),
    .byteDone(byteDone), .rxByte(rxByte),
    .dataOut0(dataOut0), .dataOut1(dataOut1)
  );

  // R9
  cs_sck_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && csN && $past(csN)) |-> $stable(sck));

  // R10
  ready_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ($past(busy) && !busy));

endmodule

// File: tb/sfci_engine_test.sv
module sfci_engine_test;

  localparam int UNIT = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN, start, io2Level, io3Level, wrenPrefix, waitBusy, mode3, miso;
  logic [7:0]  opcode, csDelay;
  logic [3:0]  lenField, divField;
  logic [31:0] wrData0, wrData1;
  logic        sck, csN, mosi, io2, io3, busy, ready;
  logic [31:0] dataOut0, dataOut1;

  sfci_engine uut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .lenField(lenField),
    .wrData0(wrData0), .wrData1(wrData1), .io2Level(io2Level), .io3Level(io3Level),
    .wrenPrefix(wrenPrefix), .waitBusy(waitBusy), .divField(divField), .mode3(mode3),
    .csDelay(csDelay), .miso(miso), .sck(sck), .csN(csN), .mosi(mosi), .io2(io2),
    .io3(io3), .busy(busy), .ready(ready), .dataOut0(dataOut0), .dataOut1(dataOut1)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] fb [16][9];
  int         fLen [16];
  int         fCnt = 0;
  int         wipLeft = 0;
  logic [7:0] resp [8];
  int         bitCnt = 0;
  bit         inFrame = 0;
  logic [7:0] acc = 0;

  function automatic logic nextBit();
    int byteNo;
    logic [7:0] b;
    byteNo = bitCnt / 8;
    if (byteNo == 0 || byteNo > 8 || fCnt >= 16) return 1'b0;
    if (fb[fCnt][0] == 8'h05) b = (wipLeft > 0) ? 8'h03 : 8'h02;
    else b = resp[byteNo-1];
    return b[7 - (bitCnt % 8)];
  endfunction

  initial miso = 1'b0;
  always @(negedge csN or posedge csN or posedge sck) begin
    if (!csN && !inFrame) begin
      inFrame = 1;
      bitCnt  = 0;
      acc     = 0;
      miso    = 1'b0;
    end else if (!csN && inFrame) begin
      acc = {acc[6:0], mosi};
      if (bitCnt % 8 == 7 && bitCnt / 8 < 9 && fCnt < 16) fb[fCnt][bitCnt/8] = acc;
      bitCnt++;
      miso = nextBit();
    end else if (csN && inFrame) begin
      inFrame = 0;
      if (fCnt < 16) begin
        fLen[fCnt] = bitCnt / 8;
        if (fb[fCnt][0] == 8'h05 && wipLeft > 0) wipLeft--;
        fCnt++;
      end
    end
  end

  // ---------------- timing monitor ----------------
  logic prevCs = 1'b1, prevSck = 1'b0;
  int setupCnt, holdCnt, gapCnt, runCnt, minSetup, minHold, minGap, halfBad, curH;
  bit seenEdge, inGap, cM3;

  always @(negedge clk) begin
    if (!csN) begin
      if (prevCs) begin
        if (inGap) minGap = (gapCnt < minGap) ? gapCnt : minGap;
        inGap = 0; setupCnt = 1; seenEdge = 0; holdCnt = 0; runCnt = 0;
      end else if (sck != prevSck) begin
        if (!seenEdge) minSetup = (setupCnt < minSetup) ? setupCnt : minSetup;
        seenEdge = 1; holdCnt = 0;
        if (prevSck == !cM3 && runCnt != curH) halfBad++;
        runCnt = 0;
      end else begin
        if (!seenEdge) setupCnt++;
        holdCnt++;
      end
      if (sck == !cM3) runCnt++;
    end else begin
      if (!prevCs) begin
        minHold = (holdCnt < minHold) ? holdCnt : minHold;
        inGap = 1; gapCnt = 0;
      end
      gapCnt++;
    end
    prevCs = csN;
    prevSck = sck;
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nChecks++; nFail++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  // ---------------- command runner ----------------
  logic [7:0]  cOpc, cDly;
  logic [3:0]  cLen, cDiv;
  logic [31:0] cD0, cD1;
  bit cWren, cWait, cL2, cL3, cIgnore;
  int cWip;

  task automatic runCmd();
    int nb, idx, ns, bad, dcyc;
    logic [63:0] d64, expD;
    @(negedge clk);
    opcode = cOpc; lenField = cLen; wrData0 = cD0; wrData1 = cD1;
    wrenPrefix = cWren; waitBusy = cWait; divField = cDiv; mode3 = cM3;
    csDelay = cDly; io2Level = cL2; io3Level = cL3;
    for (int f = 0; f < 16; f++) begin
      fLen[f] = 0;
      for (int k = 0; k < 9; k++) fb[f][k] = 8'h00;
    end
    for (int k = 0; k < 8; k++) resp[k] = 8'($urandom);
    fCnt = 0; wipLeft = cWip; curH = int'(cDiv) + 1;
    minSetup = 1000000; minHold = 1000000; minGap = 1000000; halfBad = 0; inGap = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", 64'(busy), 64'd1);
    check(io2 == cL2 && io3 == cL3, "R6 io levels while busy", {io3, io2}, {cL3, cL2});
    if (cIgnore) begin
      start = 1'b1; opcode = ~cOpc; wrenPrefix = ~cWren; lenField = 4'd9;
      @(negedge clk);
      start = 1'b0;
    end
    while (!ready) @(negedge clk);
    check(busy == 1'b0, "R10 busy low with ready", 64'(busy), 64'd0);
    @(negedge clk);
    check(ready == 1'b0, "R10 ready one cycle", 64'(ready), 64'd0);
    check(io2 == 1'b1 && io3 == 1'b1, "R6 io idle high", {io3, io2}, 64'd3);
    check(sck == cM3, "R8 sck idle level", 64'(sck), 64'(cM3));

    nb = (cLen == 0) ? 1 : ((cLen > 9) ? 9 : int'(cLen));
    ns = cWait ? cWip + 1 : 0;
    idx = 0;
    if (cWren) begin
      check(fLen[0] == 1 && fb[0][0] == 8'h06, "R4 write-enable frame", {fLen[0][7:0], fb[0][0]}, 64'h0106);
      idx = 1;
    end
    d64 = {cD1, cD0};
    check(fLen[idx] == nb, "R2 command length", 64'(fLen[idx]), 64'(nb));
    check(fb[idx][0] == cOpc, "R2 opcode byte", 64'(fb[idx][0]), 64'(cOpc));
    bad = 0;
    for (int k = 0; k < nb - 1; k++) if (fb[idx][k+1] != d64[k*8 +: 8]) bad++;
    check(bad == 0, "R2 data bytes", 64'(bad), 64'd0);
    check(fCnt == idx + 1 + ns, "R5 frame count", 64'(fCnt), 64'(idx + 1 + ns));
    bad = 0;
    for (int f = idx + 1; f < fCnt && f < 16; f++) if (fb[f][0] != 8'h05 || fLen[f] != 2) bad++;
    check(bad == 0, "R5 status frames", 64'(bad), 64'd0);
    expD = d64;
    for (int k = 0; k < nb - 1; k++) expD[k*8 +: 8] = resp[k];
    check({dataOut1, dataOut0} == expD, "R3 result words", {dataOut1, dataOut0}, expD);
    dcyc = int'(cDly) * UNIT;
    check(minSetup >= dcyc, "R9 cs to first edge", 64'(minSetup), 64'(dcyc));
    check(minHold >= dcyc, "R9 last edge to cs", 64'(minHold), 64'(dcyc));
    if (fCnt > 1) check(minGap >= dcyc, "R9 cs high gap", 64'(minGap), 64'(dcyc));
    check(halfBad == 0, "R7 half period", 64'(halfBad), 64'd0);
  endtask

  task automatic setCfg(input logic [7:0] opc, input logic [3:0] len, input bit wr, input bit wt,
                        input int wip, input logic [3:0] dv, input bit m3, input logic [7:0] dl);
    cOpc = opc; cLen = len; cWren = wr; cWait = wt; cWip = wip; cDiv = dv; cM3 = m3; cDly = dl;
    cD0 = $urandom; cD1 = $urandom; cL2 = 1'($urandom); cL3 = 1'($urandom); cIgnore = 0;
  endtask

  initial begin
    int seedDummy;
    logic [63:0] held;
    seedDummy = $urandom(32'd4242);
    rstN = 1'b0; start = 1'b0; opcode = 0; lenField = 0; wrData0 = 0; wrData1 = 0;
    io2Level = 0; io3Level = 0; wrenPrefix = 0; waitBusy = 0; divField = 0; mode3 = 0; csDelay = 0;
    cM3 = 0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && busy == 1'b0 && ready == 1'b0, "R1 reset control", {csN, busy, ready}, 64'b100);
    check(sck == 1'b0 && io2 == 1'b1 && io3 == 1'b1, "R1 reset lines", {sck, io2, io3}, 64'b011);

    // directed corners
    setCfg(8'h9F, 4'd0, 0, 0, 0, 4'd0, 0, 8'd0);  runCmd();   // R2 length 0 -> 1
    setCfg(8'h4B, 4'd15, 0, 0, 0, 4'd1, 0, 8'd2); runCmd();   // R2 length above 9 -> 9
    setCfg(8'hC3, 4'd9, 0, 0, 0, 4'd2, 1, 8'd1);  runCmd();   // R8 mode 3 full length
    setCfg(8'h20, 4'd4, 1, 1, 3, 4'd0, 0, 8'd3);  runCmd();   // R4 R5 prefix and three busy polls
    setCfg(8'h01, 4'd2, 1, 0, 0, 4'd15, 1, 8'd5); runCmd();   // R7 slowest divider
    setCfg(8'h35, 4'd6, 0, 1, 0, 4'd3, 0, 8'd0);  runCmd();   // R5 single poll
    setCfg(8'h5A, 4'd5, 0, 0, 0, 4'd1, 0, 8'd1);
    cIgnore = 1; runCmd();                                      // R11 restart while busy

    for (int i = 0; i < 24; i++) begin
      setCfg(8'($urandom), 4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom),
             $urandom_range(0, 3), 4'($urandom_range(0, 7)), 1'($urandom), 8'($urandom_range(0, 4)));
      cIgnore = 1'($urandom);
      runCmd();
    end

    // R3 results held while inputs change
    held = {dataOut1, dataOut0};
    @(negedge clk);
    wrData0 = ~wrData0; wrData1 = ~wrData1; opcode = ~opcode;
    repeat (20) @(negedge clk);
    check({dataOut1, dataOut0} == held, "R3 results held", {dataOut1, dataOut0}, held);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule